// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

An eight-pin general-purpose I/O block attached to an APB-style register bus. Software reaches the pin data through a window of word addresses in which address bits [9:2] serve as a per-pin mask. A write changes only the pins whose mask bit is set. A read returns zero for every pin whose mask bit is clear. Any subset of pins can therefore be set, cleared or sampled in one bus access, with no read-modify-write sequence and no race against other code that owns the other pins.

A direction word selects, pin by pin, whether the stored data value drives the pin or the pin is sampled as an input. Input levels pass through a two-stage synchroniser before they reach the bus. The stored data drives the output bus at all times. The direction word drives the output-enable bus, so only pins marked as outputs actually reach the pads.

Top module: `gpio_masked_port`

## Requirements
- R1: A bus write whose byte offset is below 0x400 is a data write, and its mask is `paddr[9:2]` (bit n of the mask belongs to pin n). On the access-phase clock edge, each pin whose mask bit is 1 takes `pwdata[n]`. Each pin whose mask bit is 0 keeps its stored value.
- R2: A bus read whose byte offset is below 0x400 returns 0 in every `prdata` bit whose mask bit `paddr[n+2]` is 0. `prdata[31:8]` is always 0.
- R3: On such a read, a pin whose direction bit is 1 (output) returns its stored data value when its mask bit is 1.
- R4: On such a read, a pin whose direction bit is 0 (input) returns, when its mask bit is 1, the level that `gpio_in` had two rising clock edges before the read is sampled.
- R5: Byte offset 0x400 holds the direction word, and a 1 in bit n makes pin n an output. A write there loads `pwdata[7:0]`, a read there returns it, and `gpio_oe` equals it at all times.
- R6: `gpio_out` equals the stored data word in every bit, whatever the direction bits are.
- R7: While `rst` is high, the stored data word, the direction word and the synchroniser are all cleared. `gpio_out`, `gpio_oe` and `prdata` (with no read in progress) are then 0.
- R8: Offsets above 0x400 are unmapped. Reads from them return 0, and writes to them change neither `gpio_out` nor `gpio_oe`. `paddr[1:0]` is ignored for decoding.
- R9: `pready` is always 1 (no wait states). A write takes effect only on an edge where `psel`, `penable` and `pwrite` are all high. A setup phase that is abandoned before its access phase changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access-phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| pready | output | 1 | Transfer ready, always high |
| gpio_in | input | 8 | Pin input levels |
| gpio_out | output | 8 | Pin output values |
| gpio_oe | output | 8 | Per-pin output enable |

## Verification
A write is due on `gpio_out` and `gpio_oe` at the first falling edge after its access-phase rising edge. Read data is combinational during the access phase and reflects register state as of the preceding rising edge. A change on `gpio_in` becomes readable two rising edges after it is applied. The bench drives every input one nanosecond after a rising edge and samples every output on the falling edge. It keeps a history queue of the input levels seen at each rising edge and takes the expected input value from the entry two edges back, so each result is compared in the exact cycle it becomes due.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS  = 8;
    localparam int BUS_W = 32;

    typedef logic [PINS-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        pin_vec_t mask;
        logic     wr;
        logic     rd;
    } bus_req_t;

    // Replace only the masked bits of a stored word.
    function automatic pin_vec_t merge_masked(pin_vec_t old_v, pin_vec_t new_v, pin_vec_t m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    // Per-pin choice between driven value and sampled level.
    function automatic pin_vec_t pick_level(pin_vec_t dir, pin_vec_t stored, pin_vec_t sampled);
        return (dir & stored) | (~dir & sampled);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output bus_req_t          req
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << PINS;

    logic [WORD_W-1:0] word;

    always_comb begin
        word     = paddr[ADDR_W-1:2];
        req.mask = paddr[PINS+1:2];
        if (word[WORD_W-1:PINS] == '0) begin
            req.sel = SEL_DATA;
        end else if (word == DIR_WORD) begin
            req.sel = SEL_DIR;
        end else begin
            req.sel = SEL_NONE;
        end
        req.wr = psel & penable & pwrite;
        req.rd = psel & ~pwrite;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t din,
    output pin_vec_t dout
);

    pin_vec_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  pin_vec_t wdata,
    output pin_vec_t data_q,
    output pin_vec_t dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_DATA: data_q <= merge_masked(data_q, wdata, req.mask);
                SEL_DIR:  dir_q  <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              pready,
    input  logic [PINS-1:0]   gpio_in,
    output logic [PINS-1:0]   gpio_out,
    output logic [PINS-1:0]   gpio_oe
);

    bus_req_t req;
    pin_vec_t data_q;
    pin_vec_t dir_q;
    pin_vec_t in_sync;
    pin_vec_t level;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .req     (req)
    );

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (gpio_in),
        .dout (in_sync)
    );

    gpio_pin_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdata  (pwdata[PINS-1:0]),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    always_comb begin
        level  = pick_level(dir_q, data_q, in_sync);
        prdata = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_DATA: prdata[PINS-1:0] = level & req.mask;
                SEL_DIR:  prdata[PINS-1:0] = dir_q;
                default:  prdata = '0;
            endcase
        end
    end

    assign pready   = 1'b1;
    assign gpio_out = data_q;
    assign gpio_oe  = dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic [7:0]        gpio_out,
    input logic [7:0]        gpio_oe
);

    logic       in_data;
    logic       in_dir;
    logic [7:0] amask;
    logic       acc_wr;

    assign in_data = (paddr < ADDR_W'(12'h400));
    assign in_dir  = (paddr[ADDR_W-1:2] == (ADDR_W-2)'(10'h100));
    assign amask   = paddr[9:2];
    assign acc_wr  = psel && penable && pwrite;

    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (gpio_out == 8'h00 && gpio_oe == 8'h00));

    a_r9_ready_high: assert property (@(posedge clk) disable iff (rst)
        pready);

    a_r1_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && in_data) |=> (((gpio_out ^ $past(gpio_out)) & ~$past(amask)) == 8'h00) && $stable(gpio_oe));

    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !in_data && !in_dir) |=> ($stable(gpio_out) && $stable(gpio_oe)));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !acc_wr |=> ($stable(gpio_out) && $stable(gpio_oe)));

    a_r2_read_mask: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && in_data) |-> ((prdata[7:0] & ~amask) == 8'h00 && prdata[31:8] == 24'h0));

    a_r3_out_readback: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && in_data) |-> (((prdata[7:0] ^ gpio_out) & gpio_oe & amask) == 8'h00));

    a_r5_dir_readback: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && in_dir) |-> (prdata == {24'h0, gpio_oe}));

    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && !in_data && !in_dir) |-> (prdata == 32'h0));

endmodule

bind gpio_masked_port gpio_masked_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .pready   (pready),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe)
);

// File: tb/test_gpio_masked_port.sv
`timescale 1ns/1ps
module test_gpio_masked_port;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  gpio_in = '0;
    logic [7:0]  gpio_out;
    logic [7:0]  gpio_oe;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done    = 0;

    // behavioural reference state
    logic [7:0] m_data;
    logic [7:0] m_dir;
    logic [7:0] in_hist[$];

    always #HALF clk = ~clk;

    gpio_masked_port i_gpio_masked_port (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] expect_read(input logic [11:0] a);
        logic [7:0] sampled;
        logic [7:0] m;
        m = a[9:2];
        sampled = (in_hist.size() >= 2) ? in_hist[in_hist.size()-2] : 8'h00;
        if (a < 12'h400) return {24'h0, ((m_dir & m_data) | (~m_dir & sampled)) & m};
        if (a[11:2] == 10'h100) return {24'h0, m_dir};
        return 32'h0;
    endfunction

    // reference model advances on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_data = 8'h00;
            m_dir  = 8'h00;
            in_hist.delete();
        end else begin
            if (psel && penable && pwrite) begin
                if (paddr < 12'h400)
                    m_data = (m_data & ~paddr[9:2]) | (pwdata[7:0] & paddr[9:2]);
                else if (paddr[11:2] == 10'h100)
                    m_dir = pwdata[7:0];
            end
            in_hist.push_back(gpio_in);
            if (in_hist.size() > 4) in_hist.delete(0);
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 R6 gpio_out", {24'h0, gpio_out}, {24'h0, m_data});
            chk("R5 gpio_oe", {24'h0, gpio_oe}, {24'h0, m_dir});
            chk("R9 pready", {31'h0, pready}, 32'h1);
            if (psel && penable && !pwrite) begin
                if (paddr < 12'h400)
                    chk("R2 R3 R4 masked read", prdata, expect_read(paddr));
                else if (paddr[11:2] == 10'h100)
                    chk("R5 direction read", prdata, expect_read(paddr));
                else
                    chk("R8 unmapped read", prdata, expect_read(paddr));
            end
        end
    end

    task automatic bus_xfer(input bit wr, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(posedge clk); #1;
        gpio_in = v;
    endtask

    task automatic finish_run;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset outputs", {16'h0, gpio_oe, gpio_out}, 32'h0);
        chk("R7 reset prdata", prdata, 32'h0);
        @(posedge clk); #1;
        rst = 1'b0;

        // direction: low nibble outputs
        bus_xfer(1, 12'h400, 32'h0000_000F);
        bus_xfer(0, 12'h400, 32'h0);
        // full-mask write then a two-bit clear
        bus_xfer(1, 12'h3FC, 32'h0000_00A5);
        bus_xfer(1, 12'h00C, 32'h0000_0000);
        bus_xfer(0, 12'h3FC, 32'h0);
        bus_xfer(0, 12'h004, 32'h0);
        // inputs on the high nibble, read right away and later
        set_pins(8'hC3);
        bus_xfer(0, 12'h3C0, 32'h0);
        set_pins(8'h3C);
        bus_xfer(0, 12'h3FC, 32'h0);
        repeat (3) @(posedge clk);
        bus_xfer(0, 12'h3FC, 32'h0);
        // zero mask: write changes nothing, read gives 0
        bus_xfer(1, 12'h000, 32'h0000_00FF);
        bus_xfer(0, 12'h000, 32'h0);
        // unmapped offsets
        bus_xfer(1, 12'h404, 32'h0000_00FF);
        bus_xfer(1, 12'hFFC, 32'h0000_00FF);
        bus_xfer(0, 12'h800, 32'h0);
        bus_xfer(0, 12'h404, 32'h0);
        // abandoned setup phase
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h3FC; pwdata = 32'h0000_005A;
        @(posedge clk); #1;
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        chk("R9 abandoned setup", {24'h0, gpio_out}, {24'h0, m_data});

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            logic [11:0] a;
            op = $urandom % 6;
            a  = {2'b00, 8'($urandom), 2'($urandom)};
            case (op)
                0: bus_xfer(1, a, $urandom);
                1, 2: bus_xfer(0, a, 32'h0);
                3: bus_xfer(1, 12'h400, $urandom);
                4: set_pins(8'($urandom));
                default: bus_xfer(($urandom % 2) == 1, 12'h400 + 12'((($urandom % 255) + 1) * 4), $urandom);
            endcase
        end

        // reset in mid-run clears everything
        bus_xfer(1, 12'h3FC, 32'h0000_00FF);
        bus_xfer(1, 12'h400, 32'h0000_00FF);
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid-run reset", {16'h0, gpio_oe, gpio_out}, 32'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        bus_xfer(0, 12'h3FC, 32'h0);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule